// File: doc/BRIEF.md
# Bi-quinary decade counter

This block is a four-stage decade counter made of two separate sections. Stage A is a single divide-by-two element with its own count input. Stages B, C and D form a divide-by-five section with a second count input. Both count inputs are asynchronous pins. Each one is brought into the system clock domain through a two-flop synchronizer, and a high-to-low transition on it becomes a one-cycle count pulse. A direct clear input resets all four stages at once and overrides any counting.

A two-bit mode input models how the two sections would be strapped together. In split mode (SPLIT) each section counts only from its own input. In BCD cascade mode (BCD) stage A takes the input pulses, and its carry (A falling from 1 to 0) steps the divide-by-five section, so QD QC QB QA count 0 to 9 in 8-4-2-1 weighting. In symmetrical mode (SYM) the divide-by-five section takes the input pulses, and its carry (D falling, state 4 to 0) toggles A. QA is then a square wave at one tenth of the input rate with 50% duty. Each carry is applied on the same clock edge as the upstream step.

Stage A is a state machine with states A_LOW and A_HIGH. Each step moves it A_LOW→A_HIGH or A_HIGH→A_LOW. The divide-by-five section is a state machine QV0→QV1→QV2→QV3→QV4→QV0 that advances one state per step. The routing decode selects SPLIT, BCD or SYM from the mode code.

Top module: `biquinary_counter`

## Requirements
- R1: While `clr` is high, `qa`, `qb`, `qc` and `qd` are all 0. The clear acts without waiting for a clock edge. `rst_n` low clears the counter and the synchronizers.
- R2: A count is taken only on a high-to-low transition of a count input. The affected outputs change on the third rising clock edge after the input falls. A low-to-high transition changes nothing.
- R3: In mode 2'b00, each falling edge on `cnt_a` toggles `qa`.
- R4: In mode 2'b00, each falling edge on `cnt_bd` steps {qd,qc,qb} (qb the LSB) through 0,1,2,3,4 and then back to 0.
- R5: In mode 2'b00, `cnt_a` has no effect on qb..qd, and `cnt_bd` has no effect on `qa`.
- R6: In mode 2'b01, `cnt_a` drives the counter and {qd,qc,qb,qa} counts 0..9, then wraps to 0. `cnt_bd` is ignored.
- R7: In mode 2'b10, `cnt_bd` steps {qd,qc,qb} through 0..4, and `qa` toggles on each 4→0 wrap. Over any 10 consecutive counts, `qa` is high after exactly 5 of them. `cnt_a` is ignored.
- R8: Mode 2'b11 behaves exactly as mode 2'b00.
- R9: In both cascaded modes, the downstream section changes on the same clock edge as the upstream stage whose carry caused it.
- R10: Falling edges on either count input while `clr` is high are ignored. After `clr` is released, counting resumes from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| clr | input | 1 | Active-high asynchronous direct clear of all four stages |
| mode | input | 2 | 00 split, 01 BCD cascade, 10 symmetrical divide-by-ten, 11 as split |
| cnt_a | input | 1 | Count input of stage A (active on falling edge) |
| cnt_bd | input | 1 | Count input of the divide-by-five section (active on falling edge) |
| qa | output | 1 | Stage A output |
| qb | output | 1 | Divide-by-five section, bit 0 |
| qc | output | 1 | Divide-by-five section, bit 1 |
| qd | output | 1 | Divide-by-five section, bit 2 |

## Verification
The assertions assume that `mode` changes only while no count pulse is in flight. They also assume that `clr` rises and falls away from the rising clock edge and stays high for at least one edge, so every stage update they check is sampled cleanly. The stimulus changes mode only after a clear with both count inputs idle high. It drives all inputs on the falling clock edge, and it holds each count input low and then high for four cycles, longer than the synchronizer delay. The counter sequences are checked by full sweeps that wrap several times, with each expected value computed by modulo arithmetic on the number of pulses applied.

// File: rtl/bq_pkg.sv
package bq_pkg;

    localparam int QUIN_W   = 3;
    localparam int QUIN_MOD = 5;

    typedef enum logic [1:0] {
        MODE_SPLIT = 2'b00,
        MODE_BCD   = 2'b01,
        MODE_SYM   = 2'b10,
        MODE_ALT   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ROUTE_SPLIT,
        ROUTE_BCD,
        ROUTE_SYM
    } route_e;

    typedef enum logic {
        A_LOW  = 1'b0,
        A_HIGH = 1'b1
    } tog_state_e;

    typedef enum logic [QUIN_W-1:0] {
        QV0 = 3'd0,
        QV1 = 3'd1,
        QV2 = 3'd2,
        QV3 = 3'd3,
        QV4 = 3'd4
    } quin_state_e;

    function automatic logic [QUIN_W-1:0] quin_next(input logic [QUIN_W-1:0] v);
        if (v >= QUIN_W'(QUIN_MOD - 1))
            return '0;
        return v + QUIN_W'(1);
    endfunction

endpackage

// File: rtl/bq_fall_detect.sv
module bq_fall_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    sync_q[i] <= 1'b1;
                else if (i == 0)
                    sync_q[i] <= din;
                else
                    sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= 1'b1;
        else
            prev_q <= sync_q[SYNC_STAGES-1];
    end

    always_comb begin
        pulse = prev_q & ~sync_q[SYNC_STAGES-1];
    end

endmodule

// File: rtl/bq_toggle_stage.sv
module bq_toggle_stage
    import bq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic q
);

    tog_state_e state_q;
    tog_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                A_LOW:  state_d = A_HIGH;
                A_HIGH: state_d = A_LOW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= A_LOW;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            A_LOW:  q = 1'b0;
            A_HIGH: q = 1'b1;
        endcase
    end

endmodule

// File: rtl/bq_quinary_stage.sv
module bq_quinary_stage
    import bq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [QUIN_W-1:0] q
);

    quin_state_e state_q;
    quin_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                QV0:     state_d = QV1;
                QV1:     state_d = QV2;
                QV2:     state_d = QV3;
                QV3:     state_d = QV4;
                QV4:     state_d = QV0;
                default: state_d = QV0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= QV0;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            QV0:     q = 3'd0;
            QV1:     q = 3'd1;
            QV2:     q = 3'd2;
            QV3:     q = 3'd3;
            QV4:     q = 3'd4;
            default: q = 3'd0;
        endcase
    end

endmodule

// File: rtl/biquinary_counter.sv
module biquinary_counter
    import bq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] mode,
    input  logic       cnt_a,
    input  logic       cnt_bd,
    output logic       qa,
    output logic       qb,
    output logic       qc,
    output logic       qd
);

    logic              edge_a;
    logic              edge_bd;
    logic              stage_rst_n;
    logic              step_a;
    logic              step_bd;
    logic              carry_a;
    logic              carry_d;
    logic [QUIN_W-1:0] quin_q;
    route_e            route;

    bq_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det_a (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cnt_a),
        .pulse (edge_a)
    );

    bq_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det_bd (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cnt_bd),
        .pulse (edge_bd)
    );

    always_comb begin
        stage_rst_n = rst_n & ~clr;
    end

    always_comb begin
        unique case (mode_e'(mode))
            MODE_SPLIT: route = ROUTE_SPLIT;
            MODE_BCD:   route = ROUTE_BCD;
            MODE_SYM:   route = ROUTE_SYM;
            MODE_ALT:   route = ROUTE_SPLIT;
        endcase
    end

    always_comb begin
        carry_a = edge_a & qa;
        carry_d = edge_bd & (quin_q == QUIN_W'(QUIN_MOD - 1));
    end

    always_comb begin
        step_a  = 1'b0;
        step_bd = 1'b0;
        unique case (route)
            ROUTE_SPLIT: begin
                step_a  = edge_a;
                step_bd = edge_bd;
            end
            ROUTE_BCD: begin
                step_a  = edge_a;
                step_bd = carry_a;
            end
            ROUTE_SYM: begin
                step_a  = carry_d;
                step_bd = edge_bd;
            end
            default: begin
                step_a  = 1'b0;
                step_bd = 1'b0;
            end
        endcase
        if (clr) begin
            step_a  = 1'b0;
            step_bd = 1'b0;
        end
    end

    bq_toggle_stage u_stage_a (
        .clk   (clk),
        .rst_n (stage_rst_n),
        .step  (step_a),
        .q     (qa)
    );

    bq_quinary_stage u_stage_bd (
        .clk   (clk),
        .rst_n (stage_rst_n),
        .step  (step_bd),
        .q     (quin_q)
    );

    always_comb begin
        qb = quin_q[0];
        qc = quin_q[1];
        qd = quin_q[2];
    end

endmodule

// File: rtl/bq_checker.sv
module bq_checker
    import bq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       clr,
    input logic [1:0] mode,
    input logic       step_a,
    input logic       step_bd,
    input logic       qa,
    input logic       qb,
    input logic       qc,
    input logic       qd
);

    logic [2:0] quin;
    assign quin = {qd, qc, qb};

    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> ({qd, qc, qb, qa} == 4'd0));

    assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        quin <= 3'd4);

    assert_a_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_a && !clr) |=> (clr || (qa != $past(qa))));

    assert_a_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_a && !clr) |=> (clr || $stable(qa)));

    assert_bd_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_bd && !clr) |=> (clr || (quin == quin_next($past(quin)))));

    assert_bd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_bd && !clr) |=> (clr || $stable(quin)));

    assert_bcd_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && step_a && qa && !clr)
            |=> (clr || (!qa && quin == quin_next($past(quin)))));

    assert_sym_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && step_bd && quin == 3'd4 && !clr)
            |=> (clr || (quin == 3'd0 && qa != $past(qa))));

endmodule

bind biquinary_counter bq_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .mode    (mode),
    .step_a  (step_a),
    .step_bd (step_bd),
    .qa      (qa),
    .qb      (qb),
    .qc      (qc),
    .qd      (qd)
);

// File: tb/tb_biquinary_counter.sv
module tb_biquinary_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       cnt_a = 1'b1;
    logic       cnt_bd = 1'b1;
    logic       qa, qb, qc, qd;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    biquinary_counter dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .mode   (mode),
        .cnt_a  (cnt_a),
        .cnt_bd (cnt_bd),
        .qa     (qa),
        .qb     (qb),
        .qc     (qc),
        .qd     (qd)
    );

    function automatic logic [3:0] outv();
        return {qd, qc, qb, qa};
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input bit on_a);
        if (on_a) cnt_a = 1'b0; else cnt_bd = 1'b0;
        repeat (4) @(negedge clk);
        if (on_a) cnt_a = 1'b1; else cnt_bd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_clear(input logic [1:0] m);
        clr = 1'b1;
        repeat (2) @(negedge clk);
        mode = m;
        clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int hi;
        @(negedge clk);
        check("R1 reset", outv(), 4'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after reset", outv(), 4'd0);

        // R3 / R5: split mode, stage A only
        for (int i = 1; i <= 12; i++) begin
            pulse(1'b1);
            check("R3 qa toggle", {3'd0, qa}, {3'd0, 1'(i % 2)});
            check("R5 quinary untouched by cnt_a", {1'b0, qd, qc, qb}, 4'd0);
        end
        // now qa = 0; R4 / R5: quinary only
        for (int i = 1; i <= 12; i++) begin
            pulse(1'b0);
            check("R4 quinary step", {1'b0, qd, qc, qb}, 4'(i % 5));
            check("R5 qa untouched by cnt_bd", {3'd0, qa}, 4'd0);
        end

        // R2 latency and rising-edge immunity
        do_clear(2'b00);
        cnt_a = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 no change after two edges", outv(), 4'd0);
        @(negedge clk);
        check("R2 change on third edge", outv(), 4'd1);
        repeat (3) @(negedge clk);
        cnt_a = 1'b1;
        repeat (6) @(negedge clk);
        check("R2 rising edge ignored", outv(), 4'd1);

        // R6: BCD cascade
        do_clear(2'b01);
        for (int i = 1; i <= 25; i++) begin
            pulse(1'b1);
            check("R6 bcd sequence", outv(), 4'(i % 10));
        end
        // value 5; cnt_bd ignored
        pulse(1'b0);
        pulse(1'b0);
        check("R6 cnt_bd ignored", outv(), 4'd5);

        // R9: carry lands on the same edge (5 -> 6 changes qa and qb)
        cnt_a = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 bcd before edge", outv(), 4'd5);
        @(negedge clk);
        check("R9 bcd same edge", outv(), 4'd6);
        repeat (3) @(negedge clk);
        cnt_a = 1'b1;
        repeat (4) @(negedge clk);

        // R7: symmetrical divide-by-ten
        do_clear(2'b10);
        hi = 0;
        for (int i = 1; i <= 20; i++) begin
            pulse(1'b0);
            check("R7 sym sequence", outv(), {3'(i % 5), 1'((i / 5) % 2)});
            if (i > 10 && qa) hi++;
        end
        checks++;
        if (hi != 5) begin
            errors++;
            $display("FAIL R7 duty: actual=%0d expected=5", hi);
        end
        pulse(1'b1);
        check("R7 cnt_a ignored", outv(), 4'd0);
        // R9 in sym: 4 -> wrap toggles qa on same edge
        for (int i = 0; i < 4; i++) pulse(1'b0);
        cnt_bd = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 sym before edge", outv(), 4'b1000);
        @(negedge clk);
        check("R9 sym same edge", outv(), 4'b0001);
        repeat (3) @(negedge clk);
        cnt_bd = 1'b1;
        repeat (4) @(negedge clk);

        // R8: mode 11 as split
        do_clear(2'b11);
        for (int i = 1; i <= 6; i++) begin
            pulse(1'b0);
            check("R8 alt quinary", outv(), {3'(i % 5), 1'b0});
        end
        pulse(1'b1);
        check("R8 alt stage A", outv(), {3'd1, 1'b1});

        // R1 / R10: clear in the middle of a BCD count
        do_clear(2'b01);
        for (int i = 0; i < 6; i++) pulse(1'b1);
        check("R10 count before clear", outv(), 4'd6);
        #1 clr = 1'b1;
        #1;
        check("R1 async clear", outv(), 4'd0);
        @(negedge clk);
        pulse(1'b1);
        pulse(1'b0);
        check("R10 pulses ignored in clear", outv(), 4'd0);
        clr = 1'b0;
        repeat (2) @(negedge clk);
        pulse(1'b1);
        check("R10 resumes from zero", outv(), 4'd1);

        finish_run();
    end

endmodule